// File: doc/BRIEF.md
# Link-Down Recovery Reset Watchdog

This block supervises a serial link that can occasionally fail to come back up on its own. On every poll, marked by a one-cycle tick, it samples a link-up status and a loopback-active flag. While the link stays down and no loopback is in use, it counts polls. Once a parameterised number of consecutive polls has passed, it issues a single-cycle recovery reset pulse. A reset pulse, a link-up poll or a loopback poll each restart the count, so the pulse repeats at the full interval for as long as the link stays down.

On each poll the block also reports whether the link state differs from the state seen at the previous poll. The reset logic that receives the pulse belongs to the surrounding design. As an example, a 10 ms tick with an interval of 500 polls gives one recovery attempt every 5 seconds.

Top module: `link_recovery_wdog`

## Requirements
- R1: After reset both outputs are 0, the poll count is zero and the remembered link state is down. The first poll that sees the link up therefore reports a change.
- R2: With the link down and loopback inactive, `recover_pulse` rises after the INTERVAL_TICKS-th consecutive such poll, and not after any earlier one.
- R3: `recover_pulse` is high for exactly one clock cycle per firing.
- R4: A poll that sees `link_up`=1 restarts the count. A full INTERVAL_TICKS of down polls is then needed before the next pulse.
- R5: A poll that sees `loopback_active`=1 restarts the count, and no pulse is issued for such a poll.
- R6: After a pulse the count restarts. While the link stays down, pulses repeat every INTERVAL_TICKS polls.
- R7: `link_changed` is 1 for one cycle after each poll whose `link_up` value differs from the value sampled at the previous poll, and 0 after polls with no difference.
- R8: On cycles with `tick`=0, changes of `link_up` and `loopback_active` are ignored: neither output rises, the poll count is kept and the remembered link state is kept.
- R9: Both outputs are registered. They appear in the clock cycle after the cycle in which `tick` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle poll strobe |
| link_up | input | 1 | Link status, 1 = up |
| loopback_active | input | 1 | 1 while any loopback mode is in use |
| recover_pulse | output | 1 | One-cycle recovery reset request |
| link_changed | output | 1 | One-cycle flag: link state differs from the previous poll |

## Verification
On every cycle, the assertions check four things. Each output follows a poll by one cycle. No pulse comes from a poll that saw the link up or a loopback. Pulses never last two cycles. The count is cleared after a restarting poll and stays below the interval. Only the bench scenarios can show the counting itself. They show that the pulse arrives on exactly the interval-th down poll and repeats at that spacing. They also show that a single link-up poll in mid-count restarts the interval, and that input changes between ticks leave the count and the remembered link state untouched.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

   // One poll as seen by the sub-blocks
   typedef struct packed {
      logic poll;   // tick sampled high
      logic link;   // link_up at this poll
      logic hold;   // timer must restart (link up or loopback)
   } poll_t;

   // Width of a counter holding 0 .. n-1
   function automatic int unsigned cnt_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lrw_poll_sample.sv
module lrw_poll_sample
   import lrw_pkg::*;
(
   input  logic  tick,
   input  logic  link_up,
   input  logic  loopback_active,
   output poll_t poll_o
);

   always_comb begin
      poll_o.poll = tick;
      poll_o.link = link_up;
      poll_o.hold = link_up | loopback_active;
   end

endmodule

// File: rtl/lrw_link_delta.sv
module lrw_link_delta (
   input  logic clk,
   input  logic rst_n,
   input  logic poll,
   input  logic link,
   output logic changed
);

   logic prev_q;
   logic chg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;   // remembered state starts as down (R1)
         chg_q  <= 1'b0;
      end else begin
         chg_q <= poll & (link ^ prev_q);
         if (poll) prev_q <= link;
      end
   end

   assign changed = chg_q;

   // R9: a change flag only follows a poll
   p_chg_after_poll_r9: assert property (@(posedge clk) disable iff (!rst_n)
      changed |-> $past(poll));

   // R8: no poll, no flag in the following cycle
   p_quiet_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !poll |=> !changed);

   // R7: a poll with the same level as the one before gives no flag
   p_same_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (poll && $past(poll) && link == $past(link)) |=> !changed);

endmodule

// File: rtl/lrw_interval_timer.sv
module lrw_interval_timer #(
   parameter int unsigned INTERVAL_TICKS = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic poll,
   input  logic hold,
   output logic fire
);

   logic fire_q;

   generate
      if (INTERVAL_TICKS < 1) begin : g_bad
         $error("lrw_interval_timer: INTERVAL_TICKS must be at least 1");
      end else if (INTERVAL_TICKS == 1) begin : g_every
         // every qualifying poll fires; no counter needed
         always_ff @(posedge clk) begin
            if (!rst_n) fire_q <= 1'b0;
            else        fire_q <= poll & ~hold;
         end
      end else begin : g_count
         localparam int unsigned CW = lrw_pkg::cnt_width(INTERVAL_TICKS);
         localparam logic [CW-1:0] LAST = CW'(INTERVAL_TICKS - 1);

         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               fire_q <= 1'b0;
            end else begin
               fire_q <= 1'b0;
               if (poll) begin
                  if (hold) begin
                     cnt_q <= '0;
                  end else if (cnt_q >= LAST) begin
                     cnt_q  <= '0;
                     fire_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
         end

         // R4/R5: a restarting poll leaves the count at zero
         p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (poll && hold) |=> (cnt_q == '0));

         // R2: the count never reaches the interval
         p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);

         // R3: at least two polls between firings, so never two cycles high
         p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
            fire_q |=> !fire_q);

         // R6: firing leaves the count restarted
         p_fire_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
            fire_q |-> (cnt_q == '0));

         // R8: without a poll the count holds
         p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !poll |=> $stable(cnt_q));
      end
   endgenerate

   assign fire = fire_q;

endmodule

// File: rtl/link_recovery_wdog.sv
module link_recovery_wdog #(
   parameter int unsigned INTERVAL_TICKS = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic link_up,
   input  logic loopback_active,
   output logic recover_pulse,
   output logic link_changed
);

   import lrw_pkg::*;

   poll_t p;

   lrw_poll_sample u_sample (
      .tick            (tick),
      .link_up         (link_up),
      .loopback_active (loopback_active),
      .poll_o          (p)
   );

   lrw_interval_timer #(
      .INTERVAL_TICKS (INTERVAL_TICKS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .poll  (p.poll),
      .hold  (p.hold),
      .fire  (recover_pulse)
   );

   lrw_link_delta u_delta (
      .clk     (clk),
      .rst_n   (rst_n),
      .poll    (p.poll),
      .link    (p.link),
      .changed (link_changed)
   );

   // R9: a pulse only follows a poll
   p_pulse_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      recover_pulse |-> $past(tick));

   // R5: no pulse from a poll that saw link up or a loopback
   p_no_pulse_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      recover_pulse |-> $past(!link_up && !loopback_active));

endmodule

// File: tb/sim_link_recovery_wdog.sv
module sim_link_recovery_wdog;

   localparam int unsigned N = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic link_up = 1'b0;
   logic loopback_active = 1'b0;
   logic recover_pulse;
   logic link_changed;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // bench model state
   int  m_cnt = 0;
   bit  m_prev = 0;

   always #5 clk = ~clk;

   link_recovery_wdog #(.INTERVAL_TICKS(N)) u0 (
      .clk (clk), .rst_n (rst_n), .tick (tick), .link_up (link_up),
      .loopback_active (loopback_active),
      .recover_pulse (recover_pulse), .link_changed (link_changed)
   );

   task automatic check(string req, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
      end
   endtask

   // one poll; called and returning at a negedge
   task automatic poll(bit lk, bit lb, string req);
      bit exp_chg, exp_fire;
      exp_chg = (lk != m_prev);
      m_prev  = lk;
      exp_fire = 0;
      if (lk || lb) m_cnt = 0;
      else begin
         m_cnt++;
         if (m_cnt >= N) begin exp_fire = 1; m_cnt = 0; end
      end
      tick = 1'b1; link_up = lk; loopback_active = lb;
      @(negedge clk);
      tick = 1'b0;
      // R9: outputs visible one cycle after the tick
      check({req, "/R9 pulse"}, recover_pulse, exp_fire);
      check({req, "/R7 changed"}, link_changed, exp_chg);
      @(negedge clk);
      // R3: pulse gone in the next cycle
      check({req, "/R3 pulse width"}, recover_pulse, 1'b0);
      check({req, "/R7 flag width"}, link_changed, 1'b0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 pulse at reset", recover_pulse, 1'b0);
      check("R1 flag at reset", link_changed, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pulse after reset", recover_pulse, 1'b0);
   endtask

   task automatic t_first_up();
      poll(1, 0, "R1 first link up");
      poll(1, 0, "R7 steady up");
   endtask

   task automatic t_fire();
      for (int i = 0; i < N; i++) poll(0, 0, "R2 count to interval");
   endtask

   task automatic t_repeat();
      for (int i = 0; i < 2 * N; i++) poll(0, 0, "R6 repeat");
   endtask

   task automatic t_link_restart();
      for (int i = 0; i < N - 2; i++) poll(0, 0, "R4 pre");
      poll(1, 0, "R4 link up");
      for (int i = 0; i < N; i++) poll(0, 0, "R4 full interval");
   endtask

   task automatic t_loopback();
      for (int i = 0; i < 2 * N; i++) poll(0, 1, "R5 loopback");
      for (int i = 0; i < N; i++) poll(0, 0, "R5 after loopback");
   endtask

   task automatic t_no_tick();
      for (int i = 0; i < N - 2; i++) poll(0, 0, "R8 pre");
      for (int i = 0; i < 20; i++) begin
         link_up = i[0]; loopback_active = i[1];
         @(negedge clk);
         check("R8 pulse idle", recover_pulse, 1'b0);
         check("R8 flag idle", link_changed, 1'b0);
      end
      // count and remembered state kept: no change flag, fires on 2nd poll
      poll(0, 0, "R8 resume 1");
      poll(0, 0, "R8 resume 2");
   endtask

   task automatic t_change_down();
      poll(1, 0, "R7 up again");
      poll(0, 1, "R7 down in loopback");
   endtask

   initial begin
      t_reset();
      t_first_up();
      t_fire();
      t_repeat();
      t_link_restart();
      t_loopback();
      t_no_tick();
      t_change_down();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule